// File: doc/BRIEF.md
# Converter Capture and Readback Interface

This block sits between a host controller's simple register bus and a pair of data converters. The host writes a control word that steers the downstream analog path. Two capture registers take the result of the input converter and the result of the output-feedback converter, each on its own conversion-complete strobe. Each capture raises a per-channel interrupt that tells the host a fresh sample is waiting.

On a read, an address-decoded multiplexer selects one of the three registers and drives it onto the data bus together with an output enable. The bus is modelled as a data-out word plus an enable, standing in for tri-state drivers. The host can therefore read back its own control word, the digitized input and the re-digitized output, and can confirm that both the control value and the analog output are what it intended.

For stand-alone use, a parameter ties the control word to a fixed constant so that the block performs one function with no bus writes.

Top module: `conv_readback_if`

## Requirements
- R1: After reset the control word equals the reset parameter (default zero), both capture registers read zero, both interrupts are low and the read enable is low.
- R2: A write cycle (bus_en=1, bus_rnw=0) to address 1 loads bus_wdata into the control word, visible on ctrl_word after the next rising clock edge.
- R3: A read cycle (bus_en=1, bus_rnw=1) to address 1 returns the current control word on bus_rdata with bus_rdata_oe high in the same cycle.
- R4: A pulse on adc_in_done captures adc_in_data at the next rising edge and raises irq_in. The captured value is returned by a read of address 2.
- R5: A pulse on adc_fb_done captures adc_fb_data at the next rising edge and raises irq_fb. The captured value is returned by a read of address 3.
- R6: An interrupt stays high until a read of its own capture address (2 for irq_in, 3 for irq_fb) is sampled at a clock edge, and then drops. Reads of other addresses leave it unchanged.
- R7: When a strobe coincides with a read of the same capture register, the read returns the old value, the new value is stored, and the interrupt stays high.
- R8: A read of address 0 drives zero with bus_rdata_oe high.
- R9: Writes to addresses 0, 2 and 3 change neither the control word nor either capture register.
- R10: Whenever no read cycle is active, bus_rdata_oe is low and bus_rdata is zero.
- R11: With STANDALONE set, ctrl_word always equals CTRL_TIE, including after reset. Writes to address 1 are ignored, and a read of address 1 returns CTRL_TIE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus cycle strobe |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, zero when not driven |
| bus_rdata_oe | output | 1 | Read data drive enable |
| adc_in_data | input | DATA_W | Input converter result |
| adc_in_done | input | 1 | Input converter conversion-complete strobe |
| adc_fb_data | input | DATA_W | Feedback converter result |
| adc_fb_done | input | 1 | Feedback converter conversion-complete strobe |
| ctrl_word | output | DATA_W | Control word to the analog path |
| irq_in | output | 1 | New input sample interrupt |
| irq_fb | output | 1 | New feedback sample interrupt |

## Verification
The main stimulus is a random mix of read and write cycles over all four addresses, with the two strobes firing independently at random. This mix separates a wrong address decode, a missed capture, a wrongly cleared interrupt and a write leaking into a read-only register.

Directed cases cover three situations. A strobe landing in the same cycle as a read of that channel separates set-priority from clear-priority. Writes aimed at the capture addresses show whether a register is read-only. A second instance with the control word tied shows that bus writes cannot alter the fixed function.

// File: rtl/conv_rb_pkg.sv
package conv_rb_pkg;
  // Read multiplexer slots; the slot index is the bus address.
  typedef enum logic [1:0] {
    SLOT_NONE = 2'd0,
    SLOT_CTRL = 2'd1,
    SLOT_IN   = 2'd2,
    SLOT_FB   = 2'd3
  } slot_e;

  localparam int NUM_CAP = 2;
  localparam int CAP_IN  = 0;
  localparam int CAP_FB  = 1;
endpackage

// File: rtl/conv_rb_rstsync.sv
module conv_rb_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic stage1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      rst_q_n  <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      rst_q_n  <= stage1_q;
    end
  end
endmodule

// File: rtl/conv_rb_ctrl_reg.sv
module conv_rb_ctrl_reg #(
  parameter int                DATA_W     = 12,
  parameter bit                STANDALONE = 1'b0,
  parameter logic [DATA_W-1:0] CTRL_TIE   = '0,
  parameter logic [DATA_W-1:0] CTRL_RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  localparam logic [DATA_W-1:0] RST_VAL    = STANDALONE ? CTRL_TIE : CTRL_RST;
  localparam logic              WR_ALLOWED = !STANDALONE;

  logic              load;
  logic [DATA_W-1:0] q_nxt;

  always_comb begin
    load  = wr_en & WR_ALLOWED;
    q_nxt = load ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/conv_rb_capture.sv
module conv_rb_capture #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done,
  input  logic [DATA_W-1:0] data,
  input  logic              ack,
  output logic [DATA_W-1:0] q,
  output logic              irq
);
  logic [DATA_W-1:0] q_nxt;
  logic              irq_nxt;

  // A new sample wins over a same-cycle acknowledge.
  always_comb begin
    q_nxt   = done ? data : q;
    irq_nxt = irq;
    if (done)     irq_nxt = 1'b1;
    else if (ack) irq_nxt = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      irq <= 1'b0;
    end else begin
      q   <= q_nxt;
      irq <= irq_nxt;
    end
  end
endmodule

// File: rtl/conv_rb_readmux.sv
module conv_rb_readmux
  import conv_rb_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int ADDR_W = 2
) (
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] sel,
  input  logic [DATA_W-1:0] ctrl,
  input  logic [DATA_W-1:0] cap_in,
  input  logic [DATA_W-1:0] cap_fb,
  output logic [DATA_W-1:0] rdata,
  output logic              oe
);
  always_comb begin
    rdata = '0;
    oe    = rd_act;
    if (rd_act) begin
      if      (sel == ADDR_W'(SLOT_CTRL)) rdata = ctrl;
      else if (sel == ADDR_W'(SLOT_IN))   rdata = cap_in;
      else if (sel == ADDR_W'(SLOT_FB))   rdata = cap_fb;
      else                                rdata = '0;
    end
  end
endmodule

// File: rtl/conv_readback_if.sv
module conv_readback_if
  import conv_rb_pkg::*;
#(
  parameter int                DATA_W     = 12,
  parameter int                ADDR_W     = 2,
  parameter bit                STANDALONE = 1'b0,
  parameter logic [DATA_W-1:0] CTRL_TIE   = '0,
  parameter logic [DATA_W-1:0] CTRL_RST   = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_rnw,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rdata_oe,
  input  logic [DATA_W-1:0] adc_in_data,
  input  logic              adc_in_done,
  input  logic [DATA_W-1:0] adc_fb_data,
  input  logic              adc_fb_done,
  output logic [DATA_W-1:0] ctrl_word,
  output logic              irq_in,
  output logic              irq_fb
);
  logic rst_q_n;
  logic rd_act, wr_act, wr_ctrl;

  logic [DATA_W-1:0] cap_data [NUM_CAP];
  logic              cap_done [NUM_CAP];
  logic              cap_ack  [NUM_CAP];
  logic [DATA_W-1:0] cap_q    [NUM_CAP];
  logic              cap_irq  [NUM_CAP];
  logic [DATA_W-1:0] cap_in_q, cap_fb_q;

  conv_rb_rstsync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  always_comb begin
    rd_act  = bus_en & bus_rnw;
    wr_act  = bus_en & ~bus_rnw;
    wr_ctrl = wr_act & (bus_addr == ADDR_W'(SLOT_CTRL));
    cap_data[CAP_IN] = adc_in_data;
    cap_done[CAP_IN] = adc_in_done;
    cap_ack[CAP_IN]  = rd_act & (bus_addr == ADDR_W'(SLOT_IN));
    cap_data[CAP_FB] = adc_fb_data;
    cap_done[CAP_FB] = adc_fb_done;
    cap_ack[CAP_FB]  = rd_act & (bus_addr == ADDR_W'(SLOT_FB));
    cap_in_q = cap_q[CAP_IN];
    cap_fb_q = cap_q[CAP_FB];
    irq_in   = cap_irq[CAP_IN];
    irq_fb   = cap_irq[CAP_FB];
  end

  conv_rb_ctrl_reg #(
    .DATA_W(DATA_W), .STANDALONE(STANDALONE),
    .CTRL_TIE(CTRL_TIE), .CTRL_RST(CTRL_RST)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .wr_en(wr_ctrl),
    .wdata(bus_wdata), .q(ctrl_word)
  );

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    conv_rb_capture #(.DATA_W(DATA_W)) u_cap (
      .clk(clk), .rst_n(rst_q_n), .done(cap_done[c]), .data(cap_data[c]),
      .ack(cap_ack[c]), .q(cap_q[c]), .irq(cap_irq[c])
    );
  end

  conv_rb_readmux #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mux (
    .rd_act(rd_act), .sel(bus_addr), .ctrl(ctrl_word),
    .cap_in(cap_in_q), .cap_fb(cap_fb_q),
    .rdata(bus_rdata), .oe(bus_rdata_oe)
  );
endmodule

// File: rtl/conv_readback_if_chk.sv
module conv_readback_if_chk #(
  parameter int                DATA_W     = 12,
  parameter int                ADDR_W     = 2,
  parameter bit                STANDALONE = 1'b0,
  parameter logic [DATA_W-1:0] CTRL_TIE   = '0
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_en,
  input logic              bus_rnw,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rdata_oe,
  input logic [DATA_W-1:0] adc_in_data,
  input logic              adc_in_done,
  input logic [DATA_W-1:0] adc_fb_data,
  input logic              adc_fb_done,
  input logic [DATA_W-1:0] ctrl_word,
  input logic [DATA_W-1:0] cap_in_q,
  input logic [DATA_W-1:0] cap_fb_q,
  input logic              irq_in,
  input logic              irq_fb
);
  logic rd, wr;
  assign rd = bus_en && bus_rnw;
  assign wr = bus_en && !bus_rnw;

  assert_bus_quiet_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd |-> (!bus_rdata_oe && bus_rdata == '0));
  assert_hole_zero_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd && bus_addr == ADDR_W'(0)) |-> (bus_rdata_oe && bus_rdata == '0));
  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!STANDALONE && wr && bus_addr == ADDR_W'(1)) |=> ctrl_word == $past(bus_wdata));
  assert_ctrl_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(wr && bus_addr == ADDR_W'(1)) |=> $stable(ctrl_word));
  assert_in_capture_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    adc_in_done |=> (irq_in && cap_in_q == $past(adc_in_data)));
  assert_fb_capture_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    adc_fb_done |=> (irq_fb && cap_fb_q == $past(adc_fb_data)));
  assert_in_clear_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd && bus_addr == ADDR_W'(2) && !adc_in_done) |=> !irq_in);
  assert_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_in && !(rd && bus_addr == ADDR_W'(2))) |=> irq_in);
  assert_fb_hold_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    (irq_fb && !(rd && bus_addr == ADDR_W'(3))) |=> irq_fb);
  assert_in_keep_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !adc_in_done |=> $stable(cap_in_q));
  assert_fixed_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    STANDALONE |-> ctrl_word == CTRL_TIE);
endmodule

bind conv_readback_if conv_readback_if_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STANDALONE(STANDALONE), .CTRL_TIE(CTRL_TIE)
) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .bus_rdata_oe(bus_rdata_oe), .adc_in_data(adc_in_data),
  .adc_in_done(adc_in_done), .adc_fb_data(adc_fb_data),
  .adc_fb_done(adc_fb_done), .ctrl_word(ctrl_word), .cap_in_q(cap_in_q),
  .cap_fb_q(cap_fb_q), .irq_in(irq_in), .irq_fb(irq_fb)
);

// File: tb/tb_conv_readback_if.sv
`timescale 1ns/1ps
module tb_conv_readback_if;
  localparam int DW = 12;
  localparam int AW = 2;
  localparam logic [DW-1:0] TIE = 12'hA5C;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_en, bus_rnw;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, adc_in_data, adc_fb_data;
  logic adc_in_done, adc_fb_done;
  logic [DW-1:0] bus_rdata, ctrl_word, f_rdata, f_ctrl;
  logic bus_rdata_oe, irq_in, irq_fb, f_oe, f_irq_in, f_irq_fb;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] m_ctrl, m_in, m_fb;
  logic m_irq_in, m_irq_fb;

  always #2.5 clk = ~clk;

  conv_readback_if #(.DATA_W(DW), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rdata_oe(bus_rdata_oe), .adc_in_data(adc_in_data),
    .adc_in_done(adc_in_done), .adc_fb_data(adc_fb_data),
    .adc_fb_done(adc_fb_done), .ctrl_word(ctrl_word),
    .irq_in(irq_in), .irq_fb(irq_fb));

  conv_readback_if #(.DATA_W(DW), .ADDR_W(AW), .STANDALONE(1'b1), .CTRL_TIE(TIE)) dut_fixed (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_rnw(bus_rnw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(f_rdata),
    .bus_rdata_oe(f_oe), .adc_in_data(adc_in_data),
    .adc_in_done(adc_in_done), .adc_fb_data(adc_fb_data),
    .adc_fb_done(adc_fb_done), .ctrl_word(f_ctrl),
    .irq_in(f_irq_in), .irq_fb(f_irq_fb));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a, input logic [DW-1:0] c);
    case (a)
      2'd1:    return c;
      2'd2:    return m_in;
      2'd3:    return m_fb;
      default: return '0;
    endcase
  endfunction

  function automatic string read_tag(input logic [AW-1:0] a);
    case (a)
      2'd1:    return "R3";
      2'd2:    return "R4";
      2'd3:    return "R5";
      default: return "R8";
    endcase
  endfunction

  // One bus cycle: check state left by earlier edges, drive, check the read path, then model the edge.
  task automatic cycle(input logic en, input logic rnw, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic di, input logic [DW-1:0] dd,
                       input logic fi, input logic [DW-1:0] fd);
    logic rd, wr;
    @(negedge clk);
    #0.5;
    chk("R2 ctrl_word", 32'(ctrl_word), 32'(m_ctrl));
    chk("R6 irq_in", 32'(irq_in), 32'(m_irq_in));
    chk("R6 irq_fb", 32'(irq_fb), 32'(m_irq_fb));
    chk("R11 fixed ctrl_word", 32'(f_ctrl), 32'(TIE));
    bus_en = en; bus_rnw = rnw; bus_addr = a; bus_wdata = wd;
    adc_in_done = di; adc_in_data = dd; adc_fb_done = fi; adc_fb_data = fd;
    #0.5;
    rd = en & rnw;
    wr = en & ~rnw;
    if (rd) begin
      chk({read_tag(a), " rdata"}, 32'(bus_rdata), 32'(exp_read(a, m_ctrl)));
      chk({read_tag(a), " oe"}, 32'(bus_rdata_oe), 32'd1);
      if (a == 2'd1) chk("R11 fixed readback", 32'(f_rdata), 32'(TIE));
    end else begin
      chk("R10 rdata idle", 32'(bus_rdata), 32'd0);
      chk("R10 oe idle", 32'(bus_rdata_oe), 32'd0);
    end
    @(posedge clk);
    if (wr && a == 2'd1) m_ctrl = wd;
    if (di) begin m_in = dd; m_irq_in = 1'b1; end
    else if (rd && a == 2'd2) m_irq_in = 1'b0;
    if (fi) begin m_fb = fd; m_irq_fb = 1'b1; end
    else if (rd && a == 2'd3) m_irq_fb = 1'b0;
  endtask

  task automatic idle();
    cycle(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b0, '0);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0;
    bus_en = 1'b0; bus_rnw = 1'b0; bus_addr = '0; bus_wdata = '0;
    adc_in_done = 1'b0; adc_fb_done = 1'b0; adc_in_data = '0; adc_fb_data = '0;
    m_ctrl = '0; m_in = '0; m_fb = '0; m_irq_in = 1'b0; m_irq_fb = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #0.5;
    // R1 reset state
    chk("R1 ctrl_word", 32'(ctrl_word), 32'd0);
    chk("R1 irq_in", 32'(irq_in), 32'd0);
    chk("R1 irq_fb", 32'(irq_fb), 32'd0);
    chk("R1 oe", 32'(bus_rdata_oe), 32'd0);
    chk("R1 R11 fixed ctrl", 32'(f_ctrl), 32'(TIE));
    cycle(1'b1, 1'b1, 2'd2, '0, 1'b0, '0, 1'b0, '0);
    cycle(1'b1, 1'b1, 2'd3, '0, 1'b0, '0, 1'b0, '0);

    // R2 / R3 write then read the control word
    cycle(1'b1, 1'b0, 2'd1, 12'h3C7, 1'b0, '0, 1'b0, '0);
    cycle(1'b1, 1'b1, 2'd1, '0, 1'b0, '0, 1'b0, '0);

    // R4 / R6: capture, read of other address keeps irq, own read clears it
    cycle(1'b0, 1'b0, '0, '0, 1'b1, 12'h5A1, 1'b0, '0);
    cycle(1'b1, 1'b1, 2'd3, '0, 1'b0, '0, 1'b0, '0);
    cycle(1'b1, 1'b1, 2'd2, '0, 1'b0, '0, 1'b0, '0);
    idle();

    // R7: strobe with read of same register; old data returned, irq stays
    cycle(1'b1, 1'b1, 2'd2, '0, 1'b1, 12'h0F3, 1'b0, '0);
    idle();
    chk("R7 irq_in held", 32'(irq_in), 32'd1);
    cycle(1'b1, 1'b1, 2'd2, '0, 1'b0, '0, 1'b0, '0);
    chk("R7 new value stored", 32'(bus_rdata), 32'h0F3);

    // R5 / R9: writes to read-only addresses leave registers untouched
    cycle(1'b0, 1'b0, '0, '0, 1'b0, '0, 1'b1, 12'h777);
    cycle(1'b1, 1'b0, 2'd3, 12'hFFF, 1'b0, '0, 1'b0, '0);
    cycle(1'b1, 1'b0, 2'd2, 12'hEEE, 1'b0, '0, 1'b0, '0);
    cycle(1'b1, 1'b0, 2'd0, 12'hDDD, 1'b0, '0, 1'b0, '0);
    cycle(1'b1, 1'b1, 2'd3, '0, 1'b0, '0, 1'b0, '0);
    chk("R9 fb capture unchanged", 32'(bus_rdata), 32'h777);
    cycle(1'b1, 1'b1, 2'd2, '0, 1'b0, '0, 1'b0, '0);
    chk("R9 in capture unchanged", 32'(bus_rdata), 32'h0F3);
    cycle(1'b1, 1'b1, 2'd1, '0, 1'b0, '0, 1'b0, '0);
    chk("R9 ctrl unchanged", 32'(bus_rdata), 32'h3C7);
    cycle(1'b1, 1'b1, 2'd0, '0, 1'b0, '0, 1'b0, '0);

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 4) != 0, $urandom % 2, AW'($urandom), DW'($urandom),
            ($urandom % 5) == 0, DW'($urandom), ($urandom % 5) == 0, DW'($urandom));
    end
    idle();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule